// File: doc/BRIEF.md
# Receive Frame Ring Buffer Manager

This block decides where incoming network frames land in a circular receive region of local memory that a host processor empties. A byte stream arrives with start-of-frame and end-of-frame markers plus per-frame result flags from upstream logic (type/length, length error, CRC error, alignment error, short frame, address match, collision). The block turns that stream into memory write strobes, addresses and data. It places the frame bytes at consecutive addresses and follows them with a two-byte status field that encodes the flags.

The host sets the lower and upper bounds of the circular region and a stop pointer through a small register port. Address arithmetic wraps from the upper bound back to the lower bound, so a frame may straddle the wrap point. The host advances the stop pointer as it consumes data. Before every write the block compares its write pointer with the stop pointer. If they are equal, the frame in progress is abandoned: the write pointer returns to that frame's first address, the rest of the frame is ignored, and a level interrupt and a sticky drop flag are set. Storage resumes at the next frame start for which space exists.

Top module: `rx_ring_mgr`

## Requirements
- R1: Bytes of a stored frame are written at consecutive addresses, one write per accepted byte, and each frame's first byte goes to the address right after the previous stored frame's last status byte.
- R2: A write at the address equal to the upper-bound register is followed by a write at the address held in the lower-bound register, including in the middle of a frame or its status field.
- R3: No write is ever made at the address equal to the stop register. When a write would be made there, the frame is abandoned, `irq` goes high, and the next stored frame starts at the abandoned frame's first address.
- R4: After an abandonment, the remaining bytes of that frame produce no writes. Once the stop register is moved clear, the next frame is stored normally.
- R5: Status byte 0 is bit7 = short frame, bit4 = 1, bit1 = address match, bit0 = collision, and all other bits 0.
- R6: Status byte 1 is bit7 = type/length, bit5 = receive OK (no length, CRC or alignment error), bit4 = length error, bit3 = CRC error, bit2 = alignment error, and bits 6, 1 and 0 are 0. Bit 0 (overrun) is 0 for every stored frame.
- R7: Status byte 0 is written at the address after the frame's last data byte, and status byte 1 at the address after that. The flags are sampled with the end-of-frame byte.
- R8: `irq` stays high until the host writes register 3 with bit 0 set. Register 3 reads bit0 = interrupt and bit1 = drop flag. The drop flag is set with each abandonment and cleared by writing 1 to bit 1.
- R9: After reset, registers 0 (lower bound), 1 (upper bound) and 2 (stop) read 0, all ones and 0. `irq` is 0, `mem_we` is 0, and written register values read back unchanged.
- R10: Writing register 0 also moves the write pointer to the written value, so the next stored frame starts there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_type_len | input | 1 | Type/length field flag, sampled at end of frame |
| rx_len_err | input | 1 | Length error flag |
| rx_crc_err | input | 1 | CRC error flag |
| rx_align_err | input | 1 | Alignment error flag |
| rx_short | input | 1 | Short frame flag |
| rx_ia_match | input | 1 | Individual address match flag |
| rx_collision | input | 1 | Collision seen during receive |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select: 0 lower, 1 upper, 2 stop, 3 control |
| reg_wdata | input | AW | Host write data |
| reg_rdata | output | AW | Selected register contents |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| irq | output | 1 | Ring-full interrupt, level |

## Verification
The bench stores a short frame exactly in the free space that remains after an abandonment. A design that did not roll back, or that rolled back to the wrong address, would place that frame's first byte elsewhere. A long frame crosses the upper bound with data, and one frame meets the stop pointer on its very first byte. These target an off-by-one wrap, or a missed comparison in the idle state that would write one byte over unread data. The flag patterns cover each error bit alone and in combination, so a swapped or missing status bit shows up in the compared bytes. The interrupt and drop flag are cleared one at a time to catch a shared clear.

// File: rtl/rxr_pkg.sv
// Shared types for the receive ring manager.
// Assumes byte-wide memory and a stream of one byte per valid cycle.
package rxr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BODY,
        S_DROP,
        S_STAT0,
        S_STAT1
    } wr_state_e;

    typedef struct packed {
        logic type_len;
        logic len_err;
        logic crc_err;
        logic align_err;
        logic short_frm;
        logic ia_match;
        logic collision;
    } rx_flags_t;

    localparam logic [1:0] RA_LOWER = 2'd0;
    localparam logic [1:0] RA_UPPER = 2'd1;
    localparam logic [1:0] RA_STOP  = 2'd2;
    localparam logic [1:0] RA_CTRL  = 2'd3;

endpackage

// File: rtl/rxr_host_regs.sv
// Host register file: ring bounds, stop pointer, interrupt and drop flag.
// Assumes the lower bound is only written while no frame is in flight.
// A new abandonment wins over a clear in the same cycle.
module rxr_host_regs
    import rxr_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    input  logic          halt,
    output logic [AW-1:0] lower,
    output logic [AW-1:0] upper,
    output logic [AW-1:0] stop,
    output logic          load_lower,
    output logic          irq,
    output logic          drop_flag,
    output logic [AW-1:0] reg_rdata
);

    logic ctrl_wr;
    assign ctrl_wr    = reg_wr && (reg_addr == RA_CTRL);
    assign load_lower = reg_wr && (reg_addr == RA_LOWER);

    // Pointer registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lower <= '0;
            upper <= '1;
            stop  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_LOWER: lower <= reg_wdata;
                RA_UPPER: upper <= reg_wdata;
                RA_STOP:  stop  <= reg_wdata;
                default:  ;
            endcase
        end
    end

    // Level interrupt and sticky drop flag, set on abandonment, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq       <= 1'b0;
            drop_flag <= 1'b0;
        end else begin
            if (halt)
                irq <= 1'b1;
            else if (ctrl_wr && reg_wdata[0])
                irq <= 1'b0;
            if (halt)
                drop_flag <= 1'b1;
            else if (ctrl_wr && reg_wdata[1])
                drop_flag <= 1'b0;
        end
    end

    // Read mux for the selected register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_LOWER: reg_rdata = lower;
            RA_UPPER: reg_rdata = upper;
            RA_STOP:  reg_rdata = stop;
            default:  reg_rdata[1:0] = {drop_flag, irq};
        endcase
    end

    p_irq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> irq);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(ctrl_wr && reg_wdata[0])) |=> irq);

    p_drop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_flag && !(ctrl_wr && reg_wdata[1])) |=> drop_flag);

endmodule

// File: rtl/rxr_status_gen.sv
// Builds the two status bytes from the flags captured at end of frame.
// Stored frames are never overrun, so the overrun position is always 0.
module rxr_status_gen
    import rxr_pkg::*;
(
    input  rx_flags_t flags,
    output logic [7:0] stat0,
    output logic [7:0] stat1
);

    logic rx_ok;

    // Receive OK when none of the frame-level errors is present.
    always_comb begin
        rx_ok = !(flags.len_err || flags.crc_err || flags.align_err);
    end

    // Byte 0: short frame, fixed one, address match, collision.
    always_comb begin
        stat0    = 8'h00;
        stat0[7] = flags.short_frm;
        stat0[4] = 1'b1;
        stat0[1] = flags.ia_match;
        stat0[0] = flags.collision;
    end

    // Byte 1: type/length, OK, the three errors; bits 6, 1 and 0 stay zero.
    always_comb begin
        stat1    = 8'h00;
        stat1[7] = flags.type_len;
        stat1[5] = rx_ok;
        stat1[4] = flags.len_err;
        stat1[3] = flags.crc_err;
        stat1[2] = flags.align_err;
    end

endmodule

// File: rtl/rxr_wr_ctrl.sv
// Write sequencer: places frame bytes and status bytes into the ring.
// Compares the write pointer with the stop pointer before every write,
// rolls back to the frame start on a collision, and drops the rest of it.
// Assumes at least two idle stream cycles after each end of frame.
module rxr_wr_ctrl
    import rxr_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  rx_flags_t     rx_flags,
    input  logic [AW-1:0] lower,
    input  logic [AW-1:0] upper,
    input  logic [AW-1:0] stop,
    input  logic          load_lower,
    input  logic [AW-1:0] load_value,
    input  logic [7:0]    stat0,
    input  logic [7:0]    stat1,
    output rx_flags_t     flags_q,
    output logic          halt,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    wr_state_e     state, nstate;
    logic [AW-1:0] wp, fstart, wp_next, back;
    logic          full, do_wr, take_flags;
    logic [7:0]    wdata;

    // Ring-full test and modular pointer advance between the bounds.
    always_comb begin
        full    = (wp == stop);
        wp_next = (wp == upper) ? lower : (wp + ONE);
        back    = (state == S_IDLE) ? wp : fstart;
    end

    // Next-state and write decision for the current byte or status slot.
    always_comb begin
        nstate     = state;
        do_wr      = 1'b0;
        halt       = 1'b0;
        take_flags = 1'b0;
        wdata      = rx_data;
        case (state)
            S_IDLE, S_BODY: begin
                if (rx_valid && (rx_sof || state == S_BODY)) begin
                    if (full) begin
                        halt   = 1'b1;
                        nstate = rx_eof ? S_IDLE : S_DROP;
                    end else begin
                        do_wr      = 1'b1;
                        take_flags = rx_eof;
                        nstate     = rx_eof ? S_STAT0 : S_BODY;
                    end
                end
            end
            S_DROP: begin
                if (rx_valid && rx_eof)
                    nstate = S_IDLE;
            end
            S_STAT0, S_STAT1: begin
                wdata = (state == S_STAT0) ? stat0 : stat1;
                if (full) begin
                    halt   = 1'b1;
                    nstate = S_IDLE;
                end else begin
                    do_wr  = 1'b1;
                    nstate = (state == S_STAT0) ? S_STAT1 : S_IDLE;
                end
            end
            default: nstate = S_IDLE;
        endcase
    end

    // State, pointers and registered memory write outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            wp        <= '0;
            fstart    <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            flags_q   <= '0;
        end else if (load_lower) begin
            state  <= S_IDLE;
            wp     <= load_value;
            fstart <= load_value;
            mem_we <= 1'b0;
        end else begin
            state  <= nstate;
            mem_we <= do_wr;
            if (do_wr) begin
                mem_addr  <= wp;
                mem_wdata <= wdata;
            end
            if (halt)
                wp <= back;
            else if (do_wr)
                wp <= wp_next;
            if (state == S_IDLE && rx_valid && rx_sof)
                fstart <= wp;
            if (take_flags)
                flags_q <= rx_flags;
        end
    end

    p_no_write_at_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr != $past(stop)));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && !load_lower && wp == upper) |=> (wp == $past(lower)));

    p_rollback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !load_lower && state != S_IDLE) |=> (wp == $past(fstart)));

    p_drop_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DROP) |=> !mem_we);

endmodule

// File: rtl/rx_ring_mgr.sv
// Top of the receive ring manager: host registers, write sequencer and
// status byte builder. Outputs are registered memory write signals and
// a level interrupt.
module rx_ring_mgr
    import rxr_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic          rx_type_len,
    input  logic          rx_len_err,
    input  logic          rx_crc_err,
    input  logic          rx_align_err,
    input  logic          rx_short,
    input  logic          rx_ia_match,
    input  logic          rx_collision,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          irq
);

    rx_flags_t     in_flags, flags_q;
    logic [AW-1:0] lower, upper, stop;
    logic          load_lower, halt, drop_flag;
    logic [7:0]    stat0, stat1;

    // Gather the per-frame flag inputs into one word.
    always_comb begin
        in_flags = '{type_len:  rx_type_len,  len_err:  rx_len_err,
                     crc_err:   rx_crc_err,   align_err: rx_align_err,
                     short_frm: rx_short,     ia_match: rx_ia_match,
                     collision: rx_collision};
    end

    rxr_host_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .halt       (halt),
        .lower      (lower),
        .upper      (upper),
        .stop       (stop),
        .load_lower (load_lower),
        .irq        (irq),
        .drop_flag  (drop_flag),
        .reg_rdata  (reg_rdata)
    );

    rxr_status_gen u_stat (
        .flags (flags_q),
        .stat0 (stat0),
        .stat1 (stat1)
    );

    rxr_wr_ctrl #(.AW(AW)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_sof     (rx_sof),
        .rx_eof     (rx_eof),
        .rx_flags   (in_flags),
        .lower      (lower),
        .upper      (upper),
        .stop       (stop),
        .load_lower (load_lower),
        .load_value (reg_wdata),
        .stat0      (stat0),
        .stat1      (stat1),
        .flags_q    (flags_q),
        .halt       (halt),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    p_irq_only_after_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> drop_flag);

endmodule

// File: tb/rx_ring_mgr_test.sv
// Scoreboard bench: the frame driver predicts every memory write into queues,
// the monitor pops and compares each write the design makes.
module rx_ring_mgr_test;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_type_len = 0, rx_len_err = 0, rx_crc_err = 0, rx_align_err = 0;
    logic          rx_short = 0, rx_ia_match = 0, rx_collision = 0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          irq;

    rx_ring_mgr #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_type_len(rx_type_len),
        .rx_len_err(rx_len_err), .rx_crc_err(rx_crc_err),
        .rx_align_err(rx_align_err), .rx_short(rx_short),
        .rx_ia_match(rx_ia_match), .rx_collision(rx_collision),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .irq(irq)
    );

    always #2 clk = ~clk;  // 250 MHz

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [AW-1:0] qa[$];
    logic [7:0]    qd[$];
    string         qt[$];

    // Reference ring state kept by the driver.
    logic [AW-1:0] m_wp, m_lo, m_up, m_stop;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [AW-1:0] a, input logic [7:0] d, input string t);
        qa.push_back(a);
        qd.push_back(d);
        qt.push_back(t);
    endtask

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] a);
        return (a == m_up) ? m_lo : a + 1'b1;
    endfunction

    // Monitor: every design write must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (qa.size() == 0) begin
                check(0, "R3 R4 unexpected write at addr", int'(mem_addr), -1);
            end else begin
                logic [AW-1:0] ea;
                logic [7:0]    ed;
                string         et;
                ea = qa.pop_front();
                ed = qd.pop_front();
                et = qt.pop_front();
                check(mem_addr == ea, {et, " address"}, int'(mem_addr), int'(ea));
                check(mem_wdata == ed, {et, " data"}, int'(mem_wdata), int'(ed));
            end
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd0) begin m_lo = d; m_wp = d; end
        if (a == 2'd1) m_up = d;
        if (a == 2'd2) m_stop = d;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
    endtask

    // fl = {type_len, len_err, crc_err, align_err, short, ia_match, collision}
    task automatic frame(input int len, input logic [7:0] seed, input logic [6:0] fl,
                         input string tag);
        logic [AW-1:0] fs;
        bit halted;
        logic [7:0] s0, s1;
        fs = m_wp;
        halted = 0;
        {rx_type_len, rx_len_err, rx_crc_err, rx_align_err,
         rx_short, rx_ia_match, rx_collision} = fl;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof = (i == 0);
            rx_eof = (i == len - 1);
            rx_data = seed + 8'(i);
            if (!halted) begin
                if (m_wp == m_stop) begin
                    halted = 1; m_wp = fs;
                end else begin
                    push(m_wp, rx_data, (m_wp == m_lo && i > 0) ? "R2 wrap" : tag);
                    m_wp = adv(m_wp);
                end
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        s0 = {fl[2], 2'b00, 1'b1, 2'b00, fl[1], fl[0]};
        s1 = {fl[6], 1'b0, !(fl[5] | fl[4] | fl[3]), fl[5], fl[4], fl[3], 2'b00};
        if (!halted) begin
            if (m_wp == m_stop) begin
                halted = 1; m_wp = fs;
            end else begin
                push(m_wp, s0, "R5 R7 status0");
                m_wp = adv(m_wp);
                if (m_wp == m_stop) begin
                    halted = 1; m_wp = fs;
                end else begin
                    push(m_wp, s1, "R6 R7 status1");
                    m_wp = adv(m_wp);
                end
            end
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_lo = '0; m_up = '1; m_stop = '0; m_wp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        check(irq == 1'b0, "R9 irq after reset", int'(irq), 0);
        check(mem_we == 1'b0, "R9 mem_we after reset", int'(mem_we), 0);
        rd_chk(2'd0, 0, "R9 lower reset");
        rd_chk(2'd1, 63, "R9 upper reset");
        rd_chk(2'd2, 0, "R9 stop reset");
        rd_chk(2'd3, 0, "R9 ctrl reset");

        wr_reg(2'd1, 6'd40);
        wr_reg(2'd2, 6'd30);
        wr_reg(2'd0, 6'd4);      // R10 also loads the write pointer
        rd_chk(2'd0, 4, "R9 lower readback");
        rd_chk(2'd1, 40, "R9 upper readback");
        rd_chk(2'd2, 30, "R9 stop readback");

        frame(5, 8'h10, 7'b0000000, "R1 R10 frame A");     // 4..8, status 9,10
        frame(3, 8'h20, 7'b0011111, "R1 frame B");         // crc+align, short, ia, col
        frame(1, 8'h30, 7'b1100000, "R1 single-byte C");   // type/len + length error
        check(irq == 1'b0, "R3 no irq while space remains", int'(irq), 0);

        frame(20, 8'h40, 7'b0000000, "R3 frame D hits stop");  // halts at 30
        check(irq == 1'b1, "R3 irq after halt", int'(irq), 1);
        rd_chk(2'd3, 3, "R8 ctrl shows irq and drop");

        frame(2, 8'h60, 7'b0100010, "R3 rollback frame E at 19");
        frame(10, 8'h70, 7'b0000000, "R3 frame F hits stop");
        repeat (10) @(negedge clk);
        check(irq == 1'b1, "R8 irq held", int'(irq), 1);

        wr_reg(2'd3, 6'd1);
        check(irq == 1'b0, "R8 irq cleared", int'(irq), 0);
        rd_chk(2'd3, 2, "R8 drop flag kept");
        wr_reg(2'd3, 6'd2);
        rd_chk(2'd3, 0, "R8 drop flag cleared");

        wr_reg(2'd2, 6'd10);
        frame(22, 8'h80, 7'b0001000, "R4 resume straddling wrap");  // 23..40, 4..7, st 8,9
        check(irq == 1'b0, "R2 wrap frame stored without halt", int'(irq), 0);
        frame(1, 8'hA0, 7'b0000000, "R3 halt on first byte");       // wp 10 == stop
        check(irq == 1'b1, "R3 irq on first-byte halt", int'(irq), 1);
        wr_reg(2'd3, 6'd3);
        wr_reg(2'd2, 6'd20);
        frame(3, 8'hB0, 7'b0000100, "R4 resumed frame at 10");      // 10..12, st 13,14
        check(irq == 1'b0, "R4 no irq after resume", int'(irq), 0);

        wr_reg(2'd0, 6'd32);
        frame(4, 8'hC0, 7'b1000000, "R10 frame at new lower");      // 32..35, st 36,37
        rd_chk(2'd0, 32, "R10 lower readback");

        repeat (5) @(negedge clk);
        check(qa.size() == 0, "R1 all expected writes seen", qa.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule